// File: doc/BRIEF.md
# Parallel-to-Serial Frame Transmitter

This block accepts a byte-wide character when a start request is raised and sends it out on one serial line at a rate of one bit per clock. The bit stream is framed like an asynchronous character. A low start bit comes first. The data bits follow with the least significant bit first. After that the line is held high, which serves as the stop level and the idle level. No baud divider sits in front of the block, so it shifts on every clock edge.

Inside, a shift register one bit wider than the character is loaded with the character and a zero below it. On each shift it moves toward bit 0 and takes in a one at the top. The serial line is always bit 0 of that register. A small counter tracks the shifting cycles, and a three-state controller (idle, shifting, done) ends the frame after ten bit times. The completion flag is the upper bit of the controller state. The start request is handled as a level: one raised start sends one character. The flag then stays up until start is dropped, and only after that can a new request be taken.

Top module: `ptsTx`

## Requirements
- R1: A synchronous reset drives sdata to 1 and done to 0 from the next clock edge onward, including when it arrives in the middle of a frame. The block restarts in the idle state.
- R2: While idle with start low, sdata is 1 and done is 0, whatever value charIn carries.
- R3: With the block idle, an edge that samples start high loads charIn. In the cycle after that edge, sdata is 0 (the start bit).
- R4: In the eight cycles that follow the start bit, sdata carries charIn bits 0 through 7 in that order.
- R5: Once the last data bit has been sent, sdata is 1 until the next start bit. Ones fill the register from the top.
- R6: The count of shifting cycles stops the frame at ten. If start is still high, done goes to 1 after the eleventh clock edge that follows the loading edge, and not before. The controller state encoding is idle 0, shifting 1, done 2, and done is state bit 1.
- R7: While done is 1 and start stays high, done stays 1.
- R8: The first edge that samples start low while done is 1 returns the block to idle, and done reads 0. A start seen on the following edge loads a new character.
- R9: If start is already low when the count reaches ten, the block returns straight to idle and done is never raised for that frame.
- R10: Changes on start during shifting or done do not reload the register or alter the bit stream. Changes on charIn after the loading edge have no effect on sdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every edge is one bit time |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Level request to send one character |
| charIn | input | DATA_W (8) | Character to send, sampled on the loading edge |
| sdata | output | 1 | Serial output line |
| done | output | 1 | High once the frame has ended while start is still held |

## Verification
The bench builds the block with the default character width of eight. With that width the counter is four bits wide and the frame lasts exactly ten bit times, so every data bit position, the start bit and the ten-count boundary can be reached with short runs. For each frame the bench derives the expected line and flag from the character and from the pattern of the start level. It covers start held for exactly eleven edges, start dropped early, start released long after the end of the frame, and start toggled in the middle of the frame. It also sends back-to-back frames and applies a reset in the middle of a frame, with charIn scrambled after the load each time.

// File: rtl/ptsTxPkg.sv
package ptsTxPkg;

  // Controller states; the completion flag is bit 1 of this encoding.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } txState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;    // capture character with a low start bit below it
    logic shift;   // move toward bit 0, one enters at the top
    logic clrCnt;  // restart the bit counter
    logic incCnt;  // count one shifting cycle
  } txStrobe_t;

endpackage

// File: rtl/txShiftReg.sv
module txShiftReg
  import ptsTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  txStrobe_t         stb,
  input  logic [DATA_W-1:0] charIn,
  output logic              sdata
);

  localparam int SR_W = DATA_W + 1;

  logic [SR_W-1:0] srQ;
  logic [SR_W-1:0] srD;

  for (genvar i = 0; i < SR_W; i++) begin : g_bit
    logic fillBit;
    logic loadBit;

    if (i == SR_W - 1) begin : g_top
      assign fillBit = 1'b1;
    end else begin : g_mid
      assign fillBit = srQ[i+1];
    end

    if (i == 0) begin : g_lsb
      assign loadBit = 1'b0;
    end else begin : g_data
      assign loadBit = charIn[i-1];
    end

    assign srD[i] = stb.load  ? loadBit :
                    stb.shift ? fillBit : srQ[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srQ <= '1;
    end else begin
      srQ <= srD;
    end
  end

  assign sdata = srQ[0];

endmodule

// File: rtl/txBitCounter.sv
module txBitCounter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc) begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/txDatapath.sv
module txDatapath
  import ptsTxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  txStrobe_t         stb,
  input  logic [DATA_W-1:0] charIn,
  output logic              sdata,
  output logic [CNT_W-1:0]  count
);

  txShiftReg #(.DATA_W(DATA_W)) shifter (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .charIn (charIn),
    .sdata  (sdata)
  );

  txBitCounter #(.CNT_W(CNT_W)) counter (
    .clk   (clk),
    .rst   (rst),
    .clr   (stb.clrCnt),
    .inc   (stb.incCnt),
    .count (count)
  );

endmodule

// File: rtl/txControl.sv
module txControl
  import ptsTxPkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int FRAME_BITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output txStrobe_t        stb,
  output logic [1:0]       state,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS);

  txState_e curState;
  txState_e nextState;

  always_ff @(posedge clk) begin
    if (rst) begin
      curState <= ST_IDLE;
    end else begin
      curState <= nextState;
    end
  end

  always_comb begin
    nextState = curState;
    stb       = '0;
    unique case (curState)
      ST_IDLE: begin
        if (start) begin
          nextState  = ST_SHIFT;
          stb.load   = 1'b1;
          stb.clrCnt = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (count == LAST_CNT) begin
          nextState = start ? ST_DONE : ST_IDLE;
        end else begin
          stb.shift  = 1'b1;
          stb.incCnt = 1'b1;
        end
      end
      ST_DONE: begin
        if (!start) begin
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign state = curState;
  assign done  = curState[1];

endmodule

// File: rtl/ptsTx.sv
module ptsTx
  import ptsTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] charIn,
  output logic              sdata,
  output logic              done
);

  localparam int FRAME_BITS = DATA_W + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  txStrobe_t        ctrlStb;
  logic [CNT_W-1:0] bitCount;
  logic [1:0]       ctrlState;

  txControl #(
    .CNT_W      (CNT_W),
    .FRAME_BITS (FRAME_BITS)
  ) control (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .count (bitCount),
    .stb   (ctrlStb),
    .state (ctrlState),
    .done  (done)
  );

  txDatapath #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) datapath (
    .clk    (clk),
    .rst    (rst),
    .stb    (ctrlStb),
    .charIn (charIn),
    .sdata  (sdata),
    .count  (bitCount)
  );

endmodule

// File: rtl/ptsTxChecker.sv
module ptsTxChecker
  import ptsTxPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 4,
  parameter int FRAME_BITS = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             sdata,
  input logic             done,
  input logic [1:0]       state,
  input logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] STOP_CNT = CNT_W'(DATA_W + 1);

  p_idle_line_high_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> sdata);

  p_load_start_bit_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=> (state == ST_SHIFT && !sdata && count == '0));

  p_stop_level_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && count >= STOP_CNT) |-> sdata);

  p_count_range_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |-> (count <= LAST_CNT));

  p_end_done_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && count == LAST_CNT && start) |=> done);

  p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> done);

  p_done_release_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (state == ST_IDLE && !done));

  p_end_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && count == LAST_CNT && !start) |=> (state == ST_IDLE && !done));

  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> !(state == ST_SHIFT && count == '0));

endmodule

bind ptsTx ptsTxChecker #(
  .DATA_W     (DATA_W),
  .CNT_W      (CNT_W),
  .FRAME_BITS (FRAME_BITS)
) chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .sdata (sdata),
  .done  (done),
  .state (ctrlState),
  .count (bitCount)
);

// File: tb/ptsTx_test.sv
module ptsTx_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic  expS;
    logic  expD;
    string tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] charIn = 8'h00;
  logic       sdata;
  logic       done;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  expItem_t expQ[$];

  ptsTx uut (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .charIn (charIn),
    .sdata  (sdata),
    .done   (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: one expectation per clock edge, sampled just after the edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      total++;
      if (sdata !== it.expS || done !== it.expD) begin
        bad++;
        $display("FAIL %s: sdata=%b done=%b expected sdata=%b done=%b",
                 it.tag, sdata, done, it.expS, it.expD);
      end
    end
  end

  // Driver: set inputs on the falling edge, queue what the next rising edge must give.
  task automatic step(input logic r, input logic s, input logic [7:0] c,
                      input logic eS, input logic eD, input string tag);
    expItem_t it;
    @(negedge clk);
    rst = r;
    start = s;
    charIn = c;
    it.expS = eS;
    it.expD = eD;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idleCycles(input int n, input logic [7:0] c);
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b0, c ^ 8'(i * 37), 1'b1, 1'b0, "R2");
    end
  endtask

  // One frame: start high for holdLen edges from the loading edge (k = 0),
  // optionally inverted at k = 3 and 4.
  task automatic frame(input logic [7:0] ch, input int holdLen, input bit glitch);
    int lastK;
    lastK = (holdLen > 11) ? holdLen : 11;
    for (int k = 0; k <= lastK; k++) begin
      logic st;
      logic eS;
      logic eD;
      string tag;
      st = (k < holdLen);
      if (glitch && (k == 3 || k == 4)) st = !st;
      if (k == 0) eS = 1'b0;
      else if (k <= 8) eS = ch[k-1];
      else eS = 1'b1;
      eD = (k >= 11) && st;
      if (k == 0) tag = "R3";
      else if (k <= 8) tag = glitch ? "R10" : "R4";
      else if (k <= 10) tag = "R5";
      else if (k == 11) tag = (holdLen > 11) ? "R6" : "R9";
      else tag = st ? "R7" : "R8";
      step(1'b0, st, (k == 0) ? ch : ~ch, eS, eD, tag);
    end
  endtask

  initial begin
    logic [7:0] lfsr;
    // R1: reset state
    step(1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, "R1");
    idleCycles(4, 8'hA5);

    frame(8'hA5, 12, 0);
    frame(8'h00, 15, 0);    // R8: back-to-back after release
    idleCycles(2, 8'h5A);
    frame(8'hFF, 1, 0);     // R9: early release
    frame(8'h01, 11, 0);    // R9: released exactly at the end
    frame(8'h80, 13, 0);
    frame(8'h5A, 14, 1);    // R10: toggled start mid-frame
    frame(8'hC3, 2, 1);     // R10: raised again while shifting
    idleCycles(3, 8'hFF);

    // R1: reset in the middle of a frame
    step(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, "R4");
    step(1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, "R4");
    step(1'b1, 1'b1, 8'hFF, 1'b1, 1'b0, "R1");
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R1");
    idleCycles(2, 8'h11);

    lfsr = 8'hB7;
    for (int n = 0; n < 24; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      frame(lfsr, 1 + (n % 16), (n % 5) == 2);
      if ((n % 3) == 0) idleCycles(1, lfsr);
    end
    idleCycles(3, 8'h00);

    repeat (3) @(posedge clk);
    #2;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    #3;
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule